// File: doc/BRIEF.md
# Framed Hex Sample Packet Transmitter

This block streams a captured block of multi-channel samples out of a block memory as printable hexadecimal text on an asynchronous serial line. A start strobe begins a transfer. The block first sends one header packet that carries two capture counters. It then sends one data packet for each sample index in the block. Each packet holds five 16-bit words, and each word becomes four hex characters. A leading marker character and a trailing marker character enclose each packet.

The serial transmitter is built in. A prescaler feeds a 16-tick oversampling counter, and together they set the bit period. The default prescale of 27 gives 230400 baud from a 100 MHz clock; 14 and 7 give the two faster rates. A busy flag stays high for the whole transfer, so the capture logic can hold off writing memory while the text is going out.

The control is one state machine with these states:
- `S_IDLE` goes to `S_LEAD` on a start strobe.
- `S_LEAD` sends the leading marker and goes to `S_FETCH` once the character is accepted.
- `S_FETCH` issues the memory read and always goes to `S_CAPT`.
- `S_CAPT` captures the word and always goes to `S_HEX`.
- `S_HEX` sends the four nibbles. After the fourth it goes back to `S_FETCH`, or to `S_TRAIL` after the fifth word.
- `S_TRAIL` sends the trailing marker. It goes to `S_LEAD` if more packets remain, or to `S_DRAIN` after the last one.
- `S_DRAIN` waits for the final stop bit and then returns to `S_IDLE`.

Top module: `hexpkt_tx`

## Requirements
- R1: After reset and whenever busy is low, the serial line is high and no memory read is issued.
- R2: Each character is framed as one start bit (0), 8 data bits sent least significant bit first, and one stop bit (1). Each bit lasts PRESCALE×16 clock cycles.
- R3: A 16-bit word is sent as four ASCII characters, most significant nibble first. Nibble values 0–9 map to 0x30–0x39 and values 10–15 map to 0x41–0x46.
- R4: Every packet is one leading marker, then 20 hex characters (five words), then the trailing marker 'X' (0x58).
- R5: The first packet of a transfer leads with 'U' (0x55) and carries, in order, 0, the sample counter, the samples-since-last-transfer counter, 0 and 0. The counters are captured at the accepted start strobe.
- R6: Data packet k (counting from 0) leads with 'Y' (0x59) and carries the memory words at addresses 5k to 5k+4 in ascending order.
- R7: A transfer with block length N sends exactly N+1 packets. A block length of 0 sends the header packet alone.
- R8: Busy rises in the cycle after an accepted start and stays high until the stop bit of the final 'X' has completed. It is low afterwards.
- R9: A start strobe while busy is ignored: the stream in progress is unchanged, and new counter or length values have no effect.
- R10: A memory read strobe is asserted with a valid address for one cycle. The returned word is taken in the following cycle, and successive reads step the address by one from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Transfer start strobe |
| blk_len_i | input | IDX_W+1 | Number of data packets (sample indices) |
| samp_cnt_i | input | 16 | Sample counter for the header packet |
| since_cnt_i | input | 16 | Samples-since-last-transfer counter for the header packet |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_data_i | input | 16 | Memory read data, one cycle after the strobe |
| txd_o | output | 1 | Serial output, idle high |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench decodes the serial line on its own and checks every character against a queue built from the requirements. A wrong lead marker, a swapped nibble order or an off-by-one in the hex letter range shows up as a miscompare on the first affected character. A second start pulse in mid-stream, carrying different counters, exposes a design that restarts or re-latches its inputs, because the header values or the packet count would change. A zero-length block and a full-length block probe the final-packet comparison, where a mistake adds or drops a whole packet. Busy is checked on every clock, so an early fall before the last stop bit ends is caught, and a read address that skips or repeats shows up in the data.

// File: rtl/hexpkt_pkg.sv
package hexpkt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_FETCH,
        S_CAPT,
        S_HEX,
        S_TRAIL,
        S_DRAIN
    } seq_state_t;

    typedef enum logic {
        U_IDLE,
        U_SEND
    } ser_state_t;

    localparam logic [7:0] MARK_FIRST = 8'h55;
    localparam logic [7:0] MARK_NEXT  = 8'h59;
    localparam logic [7:0] MARK_END   = 8'h58;

    function automatic logic [7:0] nib2ascii(input logic [3:0] n);
        if (n < 4'd10)
            return 8'h30 + {4'h0, n};
        else
            return 8'h37 + {4'h0, n};
    endfunction

endpackage

// File: rtl/hexpkt_baud.sv
module hexpkt_baud #(
    parameter int PRESCALE = 27,
    parameter int OVS      = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic bit_tick
);
    localparam int OW = (OVS > 1) ? $clog2(OVS) : 1;

    logic          os_step;
    logic [OW-1:0] os_q;

    generate
        if (PRESCALE > 1) begin : g_pre
            localparam int PW = $clog2(PRESCALE);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (!rst_n || !en)
                    pre_q <= '0;
                else if (pre_q == PW'(PRESCALE - 1))
                    pre_q <= '0;
                else
                    pre_q <= pre_q + 1'b1;
            end
            assign os_step = en && (pre_q == PW'(PRESCALE - 1));
        end else begin : g_nopre
            assign os_step = en;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            os_q <= '0;
        else if (os_step)
            os_q <= (os_q == OW'(OVS - 1)) ? '0 : os_q + 1'b1;
    end

    assign bit_tick = os_step && (os_q == OW'(OVS - 1));

endmodule

// File: rtl/hexpkt_ser.sv
module hexpkt_ser
    import hexpkt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       ld_valid,
    input  logic [7:0] ld_data,
    output logic       ld_ready,
    output logic       active,
    output logic       txd
);
    ser_state_t  st_q;
    logic [9:0]  shift_q;
    logic [3:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= U_IDLE;
            shift_q <= '1;
            cnt_q   <= '0;
        end else begin
            unique case (st_q)
                U_IDLE: begin
                    if (ld_valid) begin
                        shift_q <= {1'b1, ld_data, 1'b0};
                        cnt_q   <= '0;
                        st_q    <= U_SEND;
                    end
                end
                U_SEND: begin
                    if (bit_tick) begin
                        shift_q <= {1'b1, shift_q[9:1]};
                        if (cnt_q == 4'd9) begin
                            cnt_q <= '0;
                            st_q  <= U_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: st_q <= U_IDLE;
            endcase
        end
    end

    always_comb begin
        ld_ready = (st_q == U_IDLE);
        active   = (st_q == U_SEND);
        txd      = shift_q[0];
    end

    // R2: the bit timer only runs while a frame is in flight
    a_r2_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !bit_tick);

endmodule

// File: rtl/hexpkt_seq.sv
module hexpkt_seq
    import hexpkt_pkg::*;
#(
    parameter int VALS   = 5,
    parameter int IDX_W  = 9,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W:0]    blk_len,
    input  logic [15:0]       samp_cnt,
    input  logic [15:0]       since_cnt,
    input  logic [15:0]       mem_data,
    input  logic              chr_ready,
    input  logic              tx_active,
    output logic              chr_valid,
    output logic [7:0]        chr_data,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy
);
    localparam int VW = (VALS > 1) ? $clog2(VALS) : 1;

    seq_state_t        state_q, state_d;
    logic              hdr_q;
    logic [VW-1:0]     vsel_q;
    logic [1:0]        nib_q;
    logic [IDX_W:0]    pkt_q;
    logic [IDX_W:0]    len_q;
    logic [15:0]       samp_q, since_q;
    logic [15:0]       val_q;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       hdr_val;
    logic [3:0]        nib_sel;
    logic              last_word, last_nib, last_pkt;

    always_comb begin
        unique case (vsel_q)
            VW'(1):  hdr_val = samp_q;
            VW'(2):  hdr_val = since_q;
            default: hdr_val = 16'h0000;
        endcase
    end

    assign last_word = (vsel_q == VW'(VALS - 1));
    assign last_nib  = (nib_q == 2'd3);
    assign last_pkt  = hdr_q ? (len_q == '0) : (pkt_q == len_q - 1'b1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_LEAD;
            S_LEAD:  if (chr_ready) state_d = S_FETCH;
            S_FETCH: state_d = S_CAPT;
            S_CAPT:  state_d = S_HEX;
            S_HEX:   if (chr_ready && last_nib)
                         state_d = last_word ? S_TRAIL : S_FETCH;
            S_TRAIL: if (chr_ready)
                         state_d = last_pkt ? S_DRAIN : S_LEAD;
            S_DRAIN: if (chr_ready && !tx_active) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q   <= 1'b0;
            vsel_q  <= '0;
            nib_q   <= '0;
            pkt_q   <= '0;
            len_q   <= '0;
            samp_q  <= '0;
            since_q <= '0;
            val_q   <= '0;
            addr_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        len_q   <= blk_len;
                        samp_q  <= samp_cnt;
                        since_q <= since_cnt;
                        hdr_q   <= 1'b1;
                        pkt_q   <= '0;
                        addr_q  <= '0;
                        vsel_q  <= '0;
                        nib_q   <= '0;
                    end
                end
                S_CAPT: begin
                    if (hdr_q) begin
                        val_q <= hdr_val;
                    end else begin
                        val_q  <= mem_data;
                        addr_q <= addr_q + 1'b1;
                    end
                end
                S_HEX: begin
                    if (chr_ready) begin
                        nib_q <= nib_q + 1'b1;
                        if (last_nib)
                            vsel_q <= last_word ? '0 : vsel_q + 1'b1;
                    end
                end
                S_TRAIL: begin
                    if (chr_ready) begin
                        if (!hdr_q) pkt_q <= pkt_q + 1'b1;
                        hdr_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (nib_q)
            2'd0:    nib_sel = val_q[15:12];
            2'd1:    nib_sel = val_q[11:8];
            2'd2:    nib_sel = val_q[7:4];
            default: nib_sel = val_q[3:0];
        endcase
        chr_valid = 1'b0;
        chr_data  = 8'h00;
        unique case (state_q)
            S_LEAD: begin
                chr_valid = 1'b1;
                chr_data  = hdr_q ? MARK_FIRST : MARK_NEXT;
            end
            S_HEX: begin
                chr_valid = 1'b1;
                chr_data  = nib2ascii(nib_sel);
            end
            S_TRAIL: begin
                chr_valid = 1'b1;
                chr_data  = MARK_END;
            end
            default: ;
        endcase
        mem_rd   = (state_q == S_FETCH) && !hdr_q;
        mem_addr = addr_q;
        busy     = (state_q != S_IDLE);
    end

    // R10: every read is followed by the capture cycle
    a_r10_read_then_capture: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (state_q == S_CAPT));

    // R9: a start during a transfer leaves the latched length untouched
    a_r9_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(len_q));

endmodule

// File: rtl/hexpkt_tx.sv
module hexpkt_tx #(
    parameter int  PRESCALE = 27,
    parameter int  OVS      = 16,
    parameter int  VALS     = 5,
    parameter int  IDX_W    = 9,
    localparam int ADDR_W   = $clog2(VALS * (2 ** IDX_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W:0]    blk_len_i,
    input  logic [15:0]       samp_cnt_i,
    input  logic [15:0]       since_cnt_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [15:0]       mem_data_i,
    output logic              txd_o,
    output logic              busy_o
);
    logic       chr_valid, chr_ready, tx_active, bit_tick;
    logic [7:0] chr_data;

    hexpkt_seq #(
        .VALS   (VALS),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .blk_len   (blk_len_i),
        .samp_cnt  (samp_cnt_i),
        .since_cnt (since_cnt_i),
        .mem_data  (mem_data_i),
        .chr_ready (chr_ready),
        .tx_active (tx_active),
        .chr_valid (chr_valid),
        .chr_data  (chr_data),
        .mem_rd    (mem_rd_o),
        .mem_addr  (mem_addr_o),
        .busy      (busy_o)
    );

    hexpkt_baud #(
        .PRESCALE (PRESCALE),
        .OVS      (OVS)
    ) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_active),
        .bit_tick (bit_tick)
    );

    hexpkt_ser u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .ld_valid (chr_valid),
        .ld_data  (chr_data),
        .ld_ready (chr_ready),
        .active   (tx_active),
        .txd      (txd_o)
    );

    // R1: line rests high whenever no transfer is running
    a_r1_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> txd_o);

    // R1: no memory traffic outside a transfer
    a_r1_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_rd_o);

endmodule

// File: tb/test_hexpkt_tx.sv
module test_hexpkt_tx;
    localparam int IDX_W  = 4;
    localparam int VALS   = 5;
    localparam int PRE    = 1;
    localparam int OVS    = 16;
    localparam int BITC   = PRE * OVS;
    localparam int ADDR_W = $clog2(VALS * (2 ** IDX_W));

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [IDX_W:0]    blk_len = '0;
    logic [15:0]       samp_cnt = '0, since_cnt = '0;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_data = '0;
    logic              txd, busy;

    int vectors = 0;
    int errors = 0;
    int rx_count = 0;
    int seed = 0;
    int exp_addr = 0;
    bit done = 0;
    byte unsigned expq[$];
    string        tagq[$];

    always #10 clk = ~clk;

    hexpkt_tx #(.PRESCALE(PRE), .OVS(OVS), .VALS(VALS), .IDX_W(IDX_W)) i_hexpkt_tx (
        .clk(clk), .rst_n(rst_n), .start_i(start), .blk_len_i(blk_len),
        .samp_cnt_i(samp_cnt), .since_cnt_i(since_cnt), .mem_rd_o(mem_rd),
        .mem_addr_o(mem_addr), .mem_data_i(mem_data), .txd_o(txd), .busy_o(busy));

    function automatic logic [15:0] memf(int a);
        return 16'((a * 40503 + seed * 977) ^ (a << 7));
    endfunction

    // behavioural memory with one cycle of read latency
    always @(posedge clk) if (mem_rd) mem_data <= memf(int'(mem_addr));

    task automatic check(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic byte unsigned hexc(int n);
        return (n < 10) ? 8'(48 + n) : 8'(55 + n);
    endfunction

    task automatic push_ch(byte unsigned c, string t);
        expq.push_back(c);
        tagq.push_back(t);
    endtask

    task automatic push_val(logic [15:0] v, string t);
        for (int i = 3; i >= 0; i--) push_ch(hexc(int'(v[i*4 +: 4])), t);
    endtask

    task automatic build(int n, logic [15:0] bc, logic [15:0] sc);
        push_ch(8'h55, "R5 header lead");
        push_val(16'h0, "R5 header word0");
        push_val(bc, "R5 header sample counter");
        push_val(sc, "R5 header since counter");
        push_val(16'h0, "R5 header word3");
        push_val(16'h0, "R5 header word4");
        push_ch(8'h58, "R4 trailer");
        for (int k = 0; k < n; k++) begin
            push_ch(8'h59, "R6 data lead");
            for (int v = 0; v < VALS; v++) push_val(memf(k * VALS + v), "R6 R3 data hex");
            push_ch(8'h58, "R4 trailer");
        end
    endtask

    // serial decoder
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                logic [7:0] b;
                repeat (BITC / 2) @(negedge clk);
                check(txd === 1'b0, "R2 start bit", int'(txd), 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITC) @(negedge clk);
                    b[i] = txd;
                end
                repeat (BITC) @(negedge clk);
                check(txd === 1'b1, "R2 stop bit", int'(txd), 1);
                rx_count++;
                if (expq.size() == 0) begin
                    check(1'b0, "R7 extra character", int'(b), 0);
                end else begin
                    byte unsigned e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check(b == e, t, int'(b), int'(e));
                end
            end
        end
    end

    // per-clock checks
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (expq.size() > 0) check(busy === 1'b1, "R8 busy during transfer", int'(busy), 1);
            if (busy === 1'b0) check(txd === 1'b1, "R1 idle line", int'(txd), 1);
            if (mem_rd === 1'b1) begin
                check(int'(mem_addr) == exp_addr, "R10 read address", int'(mem_addr), exp_addr);
                exp_addr++;
            end
        end
    end

    task automatic run(int n, logic [15:0] bc, logic [15:0] sc, int sd, bit inject);
        seed = sd;
        exp_addr = 0;
        rx_count = 0;
        @(negedge clk);
        blk_len = (IDX_W + 1)'(n);
        samp_cnt = bc;
        since_cnt = sc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        build(n, bc, sc);
        check(busy === 1'b1, "R8 busy after start", int'(busy), 1);
        if (inject) begin
            repeat (2000) @(negedge clk);
            blk_len = 5'd9;
            samp_cnt = 16'hDEAD;
            since_cnt = 16'hBEEF;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (expq.size() > 0) @(negedge clk);
        repeat (BITC) @(negedge clk);
        check(busy === 1'b0, "R8 busy low after last stop bit", int'(busy), 0);
        check(rx_count == (n + 1) * 22, "R7 character count", rx_count, (n + 1) * 22);
        check(exp_addr == n * VALS, "R10 read count", exp_addr, n * VALS);
        check(txd === 1'b1, "R1 line high after transfer", int'(txd), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
        check(txd === 1'b1, "R1 reset line", int'(txd), 1);
        check(mem_rd === 1'b0, "R1 reset read", int'(mem_rd), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(busy === 1'b0, "R1 idle busy", int'(busy), 0);
        run(3, 16'h1A2F, 16'h00C5, 11, 1'b1);   // R9 start injected mid-stream
        repeat (40) @(negedge clk);
        run(0, 16'hFFFF, 16'h0000, 23, 1'b0);   // R7 header-only transfer
        repeat (40) @(negedge clk);
        run(2 ** IDX_W, 16'h9B40, 16'hA5E1, 5, 1'b0); // R7 full block
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule